// File: doc/BRIEF.md
# Multi-vector accumulator row sequencer

This control block walks one multi-vector dot-product operation through its member steps. It does no arithmetic. On a start pulse it captures the operation's fields. These are the base-register select, a 3-bit offset, the first source register index, the shared second source register index, a group size of two or four, and the value read from the selected base register. It then issues one step per member. Each step carries the first-source register, the second-source register and the accumulator-array row the datapath should update.

The accumulator array holds `VL_BITS/8` rows, and the vector length is a power-of-two parameter. That row count is split into equal stripes of `rows / group size`, called the stride. The first row is the base value plus the offset, reduced modulo the stride. Every later member lands exactly one stride further down, so each member touches its own stripe.

Steps leave on a valid/ready stream. A step is offered with `step_valid` and is consumed only in a cycle where `step_ready` is also high. While the consumer holds `step_ready` low, the offered step stays unchanged. The cycle after the final step is consumed, `done` pulses once. The register-select output `base_reg` is combinational, so the caller can fetch the base value and present it together with `start`.

Top module: `amrs_top`

## Requirements
- R1: After reset, `step_valid` and `done` are low.
- R2: `base_reg` always equals 8 plus `base_sel`, giving register numbers 8 to 11.
- R3: A `start` sampled while `step_valid` is low makes `step_valid` high on the next cycle, with `step_num` equal to 0. The row of that step is (`base_val` + `offset`) mod stride. Here stride = (`VL_BITS`/8)/G, where G is 4 when `grp4`=1 and 2 when `grp4`=0. The sum wraps at 32 bits.
- R4: An operation issues exactly G steps, numbered 0 to G-1. `step_last` is high only on step G-1.
- R5: The `step_src1` of step r equals (`src1_idx` + r) mod 32.
- R6: The `step_src2` of every step equals `src2_idx` with a 0 prepended as bit 4.
- R7: The `step_row` of step r equals the row of step 0 plus r times the stride.
- R8: While `step_valid` is high and `step_ready` is low, every step output keeps its value into the next cycle.
- R9: `done` is high for exactly one cycle: the cycle after the last step is accepted. `step_valid` is low in that cycle.
- R10: A `start` sampled while `step_valid` is high is ignored. The running operation continues unchanged, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (used only while idle) |
| grp4 | input | 1 | Group size: 1 = four members, 0 = two |
| base_sel | input | 2 | Base register select |
| base_val | input | 32 | Contents of the selected base register |
| offset | input | 3 | Row offset, 0 to 7 |
| src1_idx | input | 5 | First source register of the group |
| src2_idx | input | 4 | Shared second source register, 0 to 15 |
| base_reg | output | 5 | Register number addressed by `base_sel` |
| step_valid | output | 1 | A step is offered |
| step_ready | input | 1 | The consumer takes the offered step |
| step_src1 | output | 5 | First-source register of this step |
| step_src2 | output | 5 | Second-source register of this step |
| step_row | output | $clog2(VL_BITS/8) | Accumulator row of this step |
| step_num | output | 2 | Member number r of this step |
| step_last | output | 1 | This step is the final member |
| done | output | 1 | One-cycle pulse after the final step is accepted |

## Verification
The hardest case to reach is a start request that arrives while a stalled final step is still waiting. The block must ignore that start, and `done` must still follow exactly one cycle after the stalled step is finally taken. To get there, the stimulus drops `step_ready` at random on about a third of the cycles. On a quarter of the busy cycles it also raises `start` with fresh random fields, so ignored starts land on stalled first, middle and last steps alike. Directed operations add the two wrap cases: a base value near 2^32 with offset 7, and a first source index of 30 or 31 with four members.

// File: rtl/amrs_pkg.sv
package amrs_pkg;
  localparam int REG_IDX_W   = 5;
  localparam int SRC2_IN_W   = 4;
  localparam int BASE_SEL_W  = 2;
  localparam int OFF_W       = 3;
  localparam int BASE_W      = 32;
  localparam int NUM_W       = 2;
  localparam logic [REG_IDX_W-1:0] BASE_REG_FIRST = 5'd8;

  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_e;
endpackage

// File: rtl/amrs_plan.sv
module amrs_plan
  import amrs_pkg::*;
#(
  parameter int ROWS  = 64,
  parameter int ROW_W = 6
) (
  input  logic [BASE_SEL_W-1:0] base_sel,
  input  logic [BASE_W-1:0]     base_val,
  input  logic [OFF_W-1:0]      offset,
  input  logic                  grp4,
  output logic [REG_IDX_W-1:0]  base_reg,
  output logic [ROW_W-1:0]      first_row,
  output logic [ROW_W-1:0]      stride,
  output logic [NUM_W-1:0]      last_num
);
  localparam logic [ROW_W-1:0] STRIDE_TWO  = ROW_W'(ROWS / 2);
  localparam logic [ROW_W-1:0] STRIDE_FOUR = ROW_W'(ROWS / 4);

  logic [ROW_W-1:0] sum_lo;
  logic [ROW_W-1:0] mask;

  always_comb begin
    base_reg  = BASE_REG_FIRST | REG_IDX_W'(base_sel);
    stride    = grp4 ? STRIDE_FOUR : STRIDE_TWO;
    last_num  = grp4 ? NUM_W'(3) : NUM_W'(1);
    // stride divides 2^32, so only the low bits of the sum matter
    sum_lo    = base_val[ROW_W-1:0] + ROW_W'(offset);
    mask      = stride - ROW_W'(1);
    first_row = sum_lo & mask;
  end
endmodule

// File: rtl/amrs_walker.sv
module amrs_walker
  import amrs_pkg::*;
#(
  parameter int ROW_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [REG_IDX_W-1:0] src1_in,
  input  logic [SRC2_IN_W-1:0] src2_in,
  input  logic [ROW_W-1:0]     first_row,
  input  logic [ROW_W-1:0]     stride,
  input  logic [NUM_W-1:0]     last_num,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [REG_IDX_W-1:0] out_src1,
  output logic [REG_IDX_W-1:0] out_src2,
  output logic [ROW_W-1:0]     out_row,
  output logic [NUM_W-1:0]     out_num,
  output logic                 out_last,
  output logic                 out_done
);
  seq_state_e           state_q;
  logic [ROW_W-1:0]     stride_q;
  logic [NUM_W-1:0]     last_q;
  logic                 accept;

  assign out_valid = (state_q == SEQ_RUN);
  assign out_last  = out_valid && (out_num == last_q);
  assign accept    = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      out_done <= 1'b0;
      out_src1 <= '0;
      out_src2 <= '0;
      out_row  <= '0;
      out_num  <= '0;
      stride_q <= '0;
      last_q   <= '0;
    end else begin
      out_done <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_q  <= SEQ_RUN;
            out_src1 <= src1_in;
            out_src2 <= {1'b0, src2_in};
            out_row  <= first_row;
            out_num  <= '0;
            stride_q <= stride;
            last_q   <= last_num;
          end
        end
        SEQ_RUN: begin
          if (accept) begin
            if (out_num == last_q) begin
              state_q  <= SEQ_IDLE;
              out_done <= 1'b1;
            end else begin
              out_num  <= out_num + NUM_W'(1);
              out_src1 <= out_src1 + REG_IDX_W'(1);
              out_row  <= out_row + stride_q;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/amrs_top.sv
module amrs_top
  import amrs_pkg::*;
#(
  parameter int VL_BITS = 512,
  localparam int ROWS   = VL_BITS / 8,
  localparam int ROW_W  = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              grp4,
  input  logic [1:0]        base_sel,
  input  logic [31:0]       base_val,
  input  logic [2:0]        offset,
  input  logic [4:0]        src1_idx,
  input  logic [3:0]        src2_idx,
  output logic [4:0]        base_reg,
  output logic              step_valid,
  input  logic              step_ready,
  output logic [4:0]        step_src1,
  output logic [4:0]        step_src2,
  output logic [ROW_W-1:0]  step_row,
  output logic [1:0]        step_num,
  output logic              step_last,
  output logic              done
);
  logic [ROW_W-1:0] first_row;
  logic [ROW_W-1:0] stride;
  logic [NUM_W-1:0] last_num;

  amrs_plan #(.ROWS(ROWS), .ROW_W(ROW_W)) i_plan (
    .base_sel (base_sel),
    .base_val (base_val),
    .offset   (offset),
    .grp4     (grp4),
    .base_reg (base_reg),
    .first_row(first_row),
    .stride   (stride),
    .last_num (last_num)
  );

  amrs_walker #(.ROW_W(ROW_W)) i_walker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .src1_in  (src1_idx),
    .src2_in  (src2_idx),
    .first_row(first_row),
    .stride   (stride),
    .last_num (last_num),
    .out_ready(step_ready),
    .out_valid(step_valid),
    .out_src1 (step_src1),
    .out_src2 (step_src2),
    .out_row  (step_row),
    .out_num  (step_num),
    .out_last (step_last),
    .out_done (done)
  );
endmodule

// File: rtl/amrs_checker.sv
module amrs_checker #(
  parameter int ROW_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       base_sel,
  input logic [4:0]       base_reg,
  input logic             step_valid,
  input logic             step_ready,
  input logic [4:0]       step_src1,
  input logic [4:0]       step_src2,
  input logic [ROW_W-1:0] step_row,
  input logic [1:0]       step_num,
  input logic             step_last,
  input logic             done
);
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && !step_ready |=> step_valid && $stable(step_src1) && $stable(step_src2)
      && $stable(step_row) && $stable(step_num)); // R8
  AST_SRC2_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |-> !step_src2[4]); // R6
  AST_SRC2_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && step_ready && !step_last |=> $stable(step_src2)); // R6
  AST_SRC1_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && step_ready && !step_last |=> step_valid
      && step_src1 == $past(step_src1) + 5'd1 && step_num == $past(step_num) + 2'd1); // R5
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && step_ready && step_last |=> done && !step_valid); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_FIRST_NUM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step_valid) |-> step_num == 2'd0); // R3
  AST_LAST_ONLY_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    step_last |-> step_num[0]); // R4
  always_comb begin
    AST_BASE_REG_MAP: assert (base_reg == 5'd8 + {3'b000, base_sel}); // R2
  end
endmodule

bind amrs_top amrs_checker #(.ROW_W(ROW_W)) i_amrs_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .base_sel  (base_sel),
  .base_reg  (base_reg),
  .step_valid(step_valid),
  .step_ready(step_ready),
  .step_src1 (step_src1),
  .step_src2 (step_src2),
  .step_row  (step_row),
  .step_num  (step_num),
  .step_last (step_last),
  .done      (done)
);

// File: tb/test_amrs_top.sv
module test_amrs_top;
  localparam int VLB   = 512;
  localparam int ROWS  = VLB / 8;
  localparam int ROW_W = $clog2(ROWS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, grp4 = 1'b0, step_ready = 1'b0;
  logic [1:0] base_sel = '0;
  logic [31:0] base_val = '0;
  logic [2:0] offset = '0;
  logic [4:0] src1_idx = '0;
  logic [3:0] src2_idx = '0;
  logic [4:0] base_reg, step_src1, step_src2;
  logic step_valid, step_last, done;
  logic [ROW_W-1:0] step_row;
  logic [1:0] step_num;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  amrs_top #(.VL_BITS(VLB)) i_amrs_top (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int stride_of(input bit g4);
    return ROWS / (g4 ? 4 : 2);
  endfunction

  function automatic int row_of(input logic [31:0] bv, input int off, input bit g4, input int r);
    logic [31:0] s;
    s = bv + 32'(off);
    return int'(s % 32'(stride_of(g4))) + r * stride_of(g4);
  endfunction

  task automatic run_op(input bit g4, input logic [31:0] bv, input logic [2:0] off,
                        input logic [4:0] s1, input logic [3:0] s2, input int stall_pct);
    int cnt, r;
    bit rdy;
    cnt = g4 ? 4 : 2;
    @(negedge clk);
    start = 1'b1; grp4 = g4; base_val = bv; offset = off; src1_idx = s1; src2_idx = s2;
    step_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    r = 0;
    forever begin
      chk(step_valid === 1'b1, "R3 valid", step_valid, 1);
      chk(step_num == 2'(r), "R4 num", step_num, r);
      chk(step_last == (r == cnt - 1), "R4 last", step_last, (r == cnt - 1));
      chk(step_src1 == 5'(s1 + 5'(r)), "R5 src1", step_src1, 5'(s1 + 5'(r)));
      chk(step_src2 == {1'b0, s2}, "R6 src2", step_src2, {1'b0, s2});
      chk(int'(step_row) == row_of(bv, off, g4, r), "R7 row", step_row, row_of(bv, off, g4, r));
      rdy = ($urandom % 100) >= stall_pct;
      step_ready = rdy;
      if ($urandom % 4 == 0) begin
        // R10: start while busy must be ignored
        start = 1'b1; grp4 = $urandom; base_val = $urandom; offset = $urandom;
        src1_idx = $urandom; src2_idx = $urandom;
      end
      @(negedge clk);
      start = 1'b0;
      if (rdy) begin
        if (r == cnt - 1) break;
        r++;
      end
    end
    step_ready = 1'b0;
    chk(done === 1'b1, "R9 done", done, 1);
    chk(step_valid === 1'b0, "R9 idle", step_valid, 0);
    @(negedge clk);
    chk(done === 1'b0, "R9 pulse", done, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(step_valid === 1'b0, "R1 valid", step_valid, 0);
    chk(done === 1'b0, "R1 done", done, 0);
    for (int i = 0; i < 4; i++) begin
      base_sel = 2'(i);
      #1;
      chk(base_reg == 5'(8 + i), "R2 base_reg", base_reg, 8 + i);
    end
    run_op(1'b1, 32'hFFFF_FFFF, 3'd7, 5'd30, 4'd15, 0);
    run_op(1'b0, 32'hFFFF_FFFE, 3'd7, 5'd31, 4'd0, 50);
    run_op(1'b1, 32'd0, 3'd0, 5'd0, 4'd8, 60);
    run_op(1'b0, 32'd13, 3'd5, 5'd17, 4'd3, 0);
    for (int k = 0; k < 300; k++)
      run_op($urandom, $urandom, $urandom, $urandom, $urandom, 33);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule